// File: doc/BRIEF.md
# Second-Operand Shifter with Carry-Out

This combinational block builds the second operand of an integer datapath and reports the carry that the shift produces. A four-bit mode picks how the operand is formed. It can come from the Rm register value, shifted by a five-bit amount taken from the instruction or by an amount held in the Rs register. It can also be an 8-bit immediate rotated by an even amount, a zero-extended 12-bit immediate, a sign-extended branch offset scaled by four, or Rm passed through unchanged.

The carry output is the last bit to leave the value during the shift. The block finds it by shifting by one less than the amount and taking the bit at the exit edge. When nothing is shifted out, the incoming carry flag is passed through. Rotate-right-extended is not handled here and belongs to the arithmetic unit.

All results are available in the same cycle the inputs are applied, because the block has no registers.

Top module: `operand_shifter`

## Requirements
- R1: Mode codes 11 through 15 pass `rm_val` to `operand_out` unchanged and pass `carry_in` to `carry_out`.
- R2: Mode 0 takes `instr_lo[7:0]`, zero-extends it, and rotates it right by twice `instr_lo[11:8]`. `carry_out` is `carry_in` when that rotation is zero and `operand_out[31]` otherwise.
- R3: Modes 1, 2, 3 and 4 shift `rm_val` by `instr_lo[11:7]`, as logical left, logical right, arithmetic right and rotate right respectively. `carry_out` is the last bit shifted out. `rs_val` and `instr_lo[6:5]` have no effect.
- R4: Modes 5, 6, 7 and 8 apply the same four shift kinds with the amount taken from `rs_val[7:0]`. `rs_val[31:8]` and `instr_lo` have no effect.
- R5: In modes 1 to 8, an amount of zero leaves `rm_val` unchanged and passes `carry_in` to `carry_out`.
- R6: For logical left or logical right by 32 or more, the result is 0. At exactly 32, `carry_out` is `rm_val[0]` for left and `rm_val[31]` for right. Above 32, `carry_out` is 0.
- R7: For arithmetic right by 32 or more, every result bit equals `rm_val[31]`, and so does `carry_out`.
- R8: Rotate right by a register amount rotates by the amount modulo 32. When the amount is a nonzero multiple of 32, the result equals `rm_val` and `carry_out` is `rm_val[31]`.
- R9: Mode 9 outputs `instr_lo[11:0]` zero-extended, with `carry_out` equal to `carry_in`.
- R10: Mode 10 outputs `instr_lo[23:0]` sign-extended to 32 bits and shifted left by two, with `carry_out` equal to `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rm_val | input | 32 | Register value that is shifted or passed through |
| rs_val | input | 32 | Register whose low byte gives the shift amount in register-amount modes |
| instr_lo | input | 24 | Low instruction field: immediates, rotate field, shift amount, branch offset |
| carry_in | input | 1 | Current carry flag |
| mode | input | 4 | Operand-forming mode code |
| operand_out | output | 32 | Formed second operand |
| carry_out | output | 1 | Last bit shifted out, or `carry_in` when none |

## Verification
There are no registers, so both `operand_out` and `carry_out` settle within the cycle in which the inputs change. Their expected values are due zero cycles after the stimulus. The bench drives each vector at the falling clock edge and compares the outputs two nanoseconds later, well before the next rising edge, so every comparison sees settled values from that same vector. Expected results come from a reference that moves the value one bit position per step and records each bit as it leaves. This is a different method from the single-step shifts in the design, and it covers register amounts beyond 32 without any special cases.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  localparam int OPSH_DW     = 32;
  localparam int OPSH_AMT_W  = 8;
  localparam int OPSH_FLD_W  = 24;
  localparam int FLD_AMT_LSB = 7;
  localparam int FLD_AMT_W   = 5;
  localparam int FLD_ROT_LSB = 8;
  localparam int FLD_ROT_W   = 4;
  localparam int FLD_IMM8_W  = 8;
  localparam int FLD_IMM12_W = 12;
  localparam int BR_SCALE    = 2;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [2:0] {
    PATH_SHIFT  = 3'd0,
    PATH_ROTIMM = 3'd1,
    PATH_IMM12  = 3'd2,
    PATH_BRANCH = 3'd3,
    PATH_PASS   = 3'd4
  } opsh_path_e;
endpackage

// File: rtl/opsh_decode.sv
module opsh_decode
  import opsh_pkg::*;
(
  input  logic [3:0]  mode,
  output opsh_path_e  path,
  output shift_kind_e kind,
  output logic        amt_from_reg
);
  always_comb begin
    path         = PATH_PASS;
    kind         = SK_LSL;
    amt_from_reg = 1'b0;
    case (mode)
      4'd0:  begin path = PATH_ROTIMM; kind = SK_ROR; end
      4'd1:  begin path = PATH_SHIFT;  kind = SK_LSL; end
      4'd2:  begin path = PATH_SHIFT;  kind = SK_LSR; end
      4'd3:  begin path = PATH_SHIFT;  kind = SK_ASR; end
      4'd4:  begin path = PATH_SHIFT;  kind = SK_ROR; end
      4'd5:  begin path = PATH_SHIFT;  kind = SK_LSL; amt_from_reg = 1'b1; end
      4'd6:  begin path = PATH_SHIFT;  kind = SK_LSR; amt_from_reg = 1'b1; end
      4'd7:  begin path = PATH_SHIFT;  kind = SK_ASR; amt_from_reg = 1'b1; end
      4'd8:  begin path = PATH_SHIFT;  kind = SK_ROR; amt_from_reg = 1'b1; end
      4'd9:  path = PATH_IMM12;
      4'd10: path = PATH_BRANCH;
      default: path = PATH_PASS;
    endcase
  end
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int DW = OPSH_DW,
  parameter int AW = OPSH_AMT_W
) (
  input  logic [DW-1:0] val,
  input  logic [AW-1:0] amt,
  input  shift_kind_e   kind,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          amt_zero,
  output logic          amt_big
);
  localparam int            LW   = $clog2(DW);
  localparam logic [AW:0]   FULL = (AW+1)'(DW);
  localparam logic [AW-1:0] ONE  = AW'(1);

  // each function returns {carry, result}
  function automatic logic [DW:0] f_lsl(input logic [DW-1:0] v, input logic [AW-1:0] n);
    logic [DW-1:0] pre;
    logic [AW:0]   nx;
    nx = {1'b0, n};
    if (nx > FULL)  return '0;
    if (nx == FULL) return {v[0], {DW{1'b0}}};
    pre = v << (n - ONE);
    return {pre[DW-1], v << n};
  endfunction

  function automatic logic [DW:0] f_lsr(input logic [DW-1:0] v, input logic [AW-1:0] n);
    logic [DW-1:0] pre;
    logic [AW:0]   nx;
    nx = {1'b0, n};
    if (nx > FULL)  return '0;
    if (nx == FULL) return {v[DW-1], {DW{1'b0}}};
    pre = v >> (n - ONE);
    return {pre[0], v >> n};
  endfunction

  function automatic logic [DW:0] f_asr(input logic [DW-1:0] v, input logic [AW-1:0] n);
    logic [DW-1:0] pre;
    logic [DW-1:0] full;
    logic [AW:0]   nx;
    nx = {1'b0, n};
    if (nx >= FULL) return {v[DW-1], {DW{v[DW-1]}}};
    pre  = $signed(v) >>> (n - ONE);
    full = $signed(v) >>> n;
    return {pre[0], full};
  endfunction

  function automatic logic [DW:0] f_ror(input logic [DW-1:0] v, input logic [AW-1:0] n);
    logic [LW-1:0] r;
    logic [DW-1:0] rot;
    r = n[LW-1:0];
    if (r == '0) return {v[DW-1], v};
    rot = (v >> r) | (v << (DW - int'(r)));
    return {rot[DW-1], rot};
  endfunction

  always_comb begin
    amt_zero = (amt == '0);
    amt_big  = ({1'b0, amt} >= FULL);
    if (amt_zero) begin
      {cout, res} = {cin, val};
    end else begin
      case (kind)
        SK_LSL:  {cout, res} = f_lsl(val, amt);
        SK_LSR:  {cout, res} = f_lsr(val, amt);
        SK_ASR:  {cout, res} = f_asr(val, amt);
        default: {cout, res} = f_ror(val, amt);
      endcase
    end
  end
endmodule

// File: rtl/opsh_immgen.sv
module opsh_immgen
  import opsh_pkg::*;
#(
  parameter int DW = OPSH_DW,
  parameter int AW = OPSH_AMT_W,
  parameter int FW = OPSH_FLD_W
) (
  input  logic [FW-1:0] fld,
  output logic [DW-1:0] imm8_val,
  output logic [AW-1:0] rot_amt,
  output logic [DW-1:0] imm12_val,
  output logic [DW-1:0] branch_val
);
  function automatic logic [DW-1:0] f_branch(input logic [FW-1:0] f);
    logic [DW-1:0] ext;
    ext = DW'($signed(f));
    return ext << BR_SCALE;
  endfunction

  assign imm8_val   = DW'(fld[FLD_IMM8_W-1:0]);
  assign rot_amt    = AW'({fld[FLD_ROT_LSB +: FLD_ROT_W], 1'b0});
  assign imm12_val  = DW'(fld[FLD_IMM12_W-1:0]);
  assign branch_val = f_branch(fld);
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import opsh_pkg::*;
#(
  parameter int DW = OPSH_DW,
  parameter int AW = OPSH_AMT_W,
  parameter int FW = OPSH_FLD_W
) (
  input  logic [DW-1:0] rm_val,
  input  logic [DW-1:0] rs_val,
  input  logic [FW-1:0] instr_lo,
  input  logic          carry_in,
  input  logic [3:0]    mode,
  output logic [DW-1:0] operand_out,
  output logic          carry_out
);
  opsh_path_e    path;
  shift_kind_e   kind;
  logic          amt_from_reg;
  logic [AW-1:0] shift_amt;
  logic [DW-1:0] sh_res, rot_res, imm8_val, imm12_val, branch_val;
  logic          sh_c, rot_c, sh_zero, sh_big, rot_zero, rot_big;
  logic [AW-1:0] rot_amt;

  opsh_decode u_dec (
    .mode(mode), .path(path), .kind(kind), .amt_from_reg(amt_from_reg)
  );

  assign shift_amt = amt_from_reg ? rs_val[AW-1:0]
                                  : AW'(instr_lo[FLD_AMT_LSB +: FLD_AMT_W]);

  opsh_immgen #(.DW(DW), .AW(AW), .FW(FW)) u_imm (
    .fld(instr_lo), .imm8_val(imm8_val), .rot_amt(rot_amt),
    .imm12_val(imm12_val), .branch_val(branch_val)
  );

  opsh_barrel #(.DW(DW), .AW(AW)) u_shift (
    .val(rm_val), .amt(shift_amt), .kind(kind), .cin(carry_in),
    .res(sh_res), .cout(sh_c), .amt_zero(sh_zero), .amt_big(sh_big)
  );

  opsh_barrel #(.DW(DW), .AW(AW)) u_rot (
    .val(imm8_val), .amt(rot_amt), .kind(SK_ROR), .cin(carry_in),
    .res(rot_res), .cout(rot_c), .amt_zero(rot_zero), .amt_big(rot_big)
  );

  always_comb begin
    case (path)
      PATH_SHIFT:  begin operand_out = sh_res;     carry_out = sh_c;     end
      PATH_ROTIMM: begin operand_out = rot_res;    carry_out = rot_c;    end
      PATH_IMM12:  begin operand_out = imm12_val;  carry_out = carry_in; end
      PATH_BRANCH: begin operand_out = branch_val; carry_out = carry_in; end
      default:     begin operand_out = rm_val;     carry_out = carry_in; end
    endcase
  end
endmodule

// File: rtl/opsh_checker.sv
module opsh_checker #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int FW = 24
) (
  input logic [3:0]    mode,
  input logic [DW-1:0] rm_val,
  input logic [DW-1:0] rs_val,
  input logic [FW-1:0] instr_lo,
  input logic          carry_in,
  input logic [DW-1:0] operand_out,
  input logic          carry_out,
  input logic [AW-1:0] shift_amt,
  input logic          sh_zero,
  input logic          sh_big,
  input logic          rot_zero,
  input logic          rot_big
);
  logic shift_mode;
  assign shift_mode = (mode >= 4'd1) && (mode <= 4'd8);

  always_comb begin
    if (mode >= 4'd11)
      assert_pass_keeps_R1: assert (operand_out == rm_val && carry_out == carry_in)
        else $error("pass mode altered operand");
    if (mode == 4'd0)
      assert_rotimm_bits_R2: assert ($countones(operand_out) == $countones(instr_lo[7:0]) && !rot_big)
        else $error("rotated immediate lost bits");
    if (mode == 4'd0 && rot_zero)
      assert_rotimm_cin_R2: assert (carry_out == carry_in)
        else $error("zero rotation changed carry");
    if (mode >= 4'd5 && mode <= 4'd8)
      assert_reg_amount_R4: assert (shift_amt == rs_val[AW-1:0])
        else $error("register amount not taken from Rs");
    if (shift_mode && sh_zero)
      assert_zero_amt_R5: assert (operand_out == rm_val && carry_out == carry_in)
        else $error("zero amount changed value");
    if ((mode == 4'd5 || mode == 4'd6) && sh_big)
      assert_flush_R6: assert (operand_out == '0)
        else $error("large logical shift left bits");
    if (mode == 4'd7 && sh_big)
      assert_asr_fill_R7: assert (operand_out == {DW{rm_val[DW-1]}} && carry_out == rm_val[DW-1])
        else $error("large arithmetic shift not sign filled");
    if (mode == 4'd4 || mode == 4'd8)
      assert_ror_bits_R8: assert ($countones(operand_out) == $countones(rm_val))
        else $error("rotation changed bit count");
    if (mode == 4'd9)
      assert_imm12_R9: assert (operand_out == DW'(instr_lo[11:0]) && carry_out == carry_in)
        else $error("imm12 malformed");
    if (mode == 4'd10)
      assert_branch_R10: assert (operand_out[1:0] == 2'b00 && operand_out[25:2] == instr_lo
                                 && operand_out[DW-1:26] == {(DW-26){instr_lo[FW-1]}}
                                 && carry_out == carry_in)
        else $error("branch offset malformed");
  end
endmodule

bind operand_shifter opsh_checker #(.DW(DW), .AW(AW), .FW(FW)) u_opsh_chk (
  .mode(mode), .rm_val(rm_val), .rs_val(rs_val), .instr_lo(instr_lo),
  .carry_in(carry_in), .operand_out(operand_out), .carry_out(carry_out),
  .shift_amt(shift_amt), .sh_zero(sh_zero), .sh_big(sh_big),
  .rot_zero(rot_zero), .rot_big(rot_big)
);

// File: tb/tb_operand_shifter.sv
module tb_operand_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rm_val, rs_val;
  logic [23:0] instr_lo;
  logic        carry_in;
  logic [3:0]  mode;
  logic [31:0] operand_out;
  logic        carry_out;
  int          n_vec  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  operand_shifter dut (
    .rm_val(rm_val), .rs_val(rs_val), .instr_lo(instr_lo), .carry_in(carry_in),
    .mode(mode), .operand_out(operand_out), .carry_out(carry_out)
  );

  // One position per step; kind 0 left, 1 logical right, 2 arithmetic right, 3 rotate
  function automatic logic [32:0] ref_walk(input int k, input logic [31:0] v, input int n, input logic c);
    logic [31:0] r = v;
    logic        cc = c;
    for (int i = 0; i < n; i++) begin
      case (k)
        0: begin cc = r[31]; r = {r[30:0], 1'b0}; end
        1: begin cc = r[0];  r = {1'b0, r[31:1]}; end
        2: begin cc = r[0];  r = {r[31], r[31:1]}; end
        default: begin cc = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {cc, r};
  endfunction

  task automatic apply(input logic [3:0] m, input logic [31:0] a, input logic [31:0] s,
                       input logic [23:0] f, input logic c, input logic [32:0] exp_v,
                       input string tag);
    @(negedge clk);
    mode = m; rm_val = a; rs_val = s; instr_lo = f; carry_in = c;
    #2;
    n_vec++;
    if ({carry_out, operand_out} !== exp_v) begin
      n_fail++;
      $display("FAIL %s mode=%0d actual c=%b v=%h expected c=%b v=%h",
               tag, m, carry_out, operand_out, exp_v[32], exp_v[31:0]);
    end
  endtask

  function automatic string shift_tag(input int k, input int n, input bit from_reg);
    if (n == 0) return "R5";
    if ((k == 0 || k == 1) && n >= 32) return "R6";
    if (k == 2 && n >= 32) return "R7";
    if (k == 3 && from_reg) return "R8";
    return from_reg ? "R4" : "R3";
  endfunction

  logic [31:0] vals [6] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0001, 32'h7FFF_FFFE,
                            32'h1234_5678, 32'hA5C3_0F96};
  logic [7:0]  imm8s [8] = '{8'h01, 8'h80, 8'hFF, 8'hA5, 8'h3C, 8'h00, 8'h7E, 8'h81};
  logic [23:0] flds [7] = '{24'h000000, 24'h7FFFFF, 24'h800000, 24'hFFFFFF,
                            24'h000006, 24'h123456, 24'hABCDEF};

  initial begin
    mode = 4'd0; rm_val = '0; rs_val = '0; instr_lo = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs give a zero operand and zero carry (R2)
    apply(4'd0, 32'h0, 32'h0, 24'h0, 1'b0, 33'h0, "R2 reset");

    // immediate-amount shifts (R3, R5, R6, R7 boundaries)
    for (int k = 0; k < 4; k++)
      for (int vi = 0; vi < 6; vi++)
        for (int n = 0; n < 32; n++)
          for (int c = 0; c < 2; c++)
            apply(4'(1 + k), vals[vi], ~vals[vi],
                  {12'h3C5, 5'(n), 2'(k + 1), 5'b10101}, 1'(c),
                  ref_walk(k, vals[vi], n, 1'(c)), shift_tag(k, n, 1'b0));

    // register-amount shifts, including amounts past 32 (R4..R8)
    for (int k = 0; k < 4; k++)
      for (int vi = 0; vi < 6; vi++)
        for (int j = 0; j < 44; j++)
          for (int c = 0; c < 2; c++) begin
            int n;
            n = (j < 41) ? j : (j == 41 ? 64 : (j == 42 ? 128 : 255));
            apply(4'(5 + k), vals[vi], {24'h5A5A5A, 8'(n)}, 24'hF0F0F0, 1'(c),
                  ref_walk(k, vals[vi], n, 1'(c)), shift_tag(k, n, 1'b1));
          end

    // rotated immediate (R2)
    for (int r = 0; r < 16; r++)
      for (int ii = 0; ii < 8; ii++)
        for (int c = 0; c < 2; c++)
          apply(4'd0, 32'hDEAD_BEEF, 32'h1357_9BDF, {12'hA5A, 4'(r), imm8s[ii]}, 1'(c),
                ref_walk(3, {24'h0, imm8s[ii]}, 2 * r, 1'(c)), "R2");

    // 12-bit immediate (R9) and branch offset (R10)
    for (int fi = 0; fi < 7; fi++)
      for (int c = 0; c < 2; c++) begin
        logic [31:0] br;
        br = 32'($signed({{8{flds[fi][23]}}, flds[fi]}) * 4);
        apply(4'd9, 32'hCAFE_F00D, 32'h0, flds[fi], 1'(c),
              {1'(c), 20'h0, flds[fi][11:0]}, "R9");
        apply(4'd10, 32'hCAFE_F00D, 32'h0, flds[fi], 1'(c), {1'(c), br}, "R10");
      end

    // pass-through and unassigned codes (R1)
    for (int m = 11; m < 16; m++)
      for (int vi = 0; vi < 6; vi++)
        for (int c = 0; c < 2; c++)
          apply(4'(m), vals[vi], 32'hFFFF_FFFF, 24'hFFFFFF, 1'(c), {1'(c), vals[vi]}, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule